// File: doc/BRIEF.md
# Dual-Lane Asynchronous Serial Frame Monitor

This block listens to two asynchronous serial lines, a receive lane and a transmit lane, and turns the traffic on each into decoded data words. Both lanes run their own frame state machine but obey one shared set of run-time settings: the bit period, the data width (5 to 9 bits), the bit order and the parity mode. Each line idles high. A frame is recognised from a high-to-low transition, and every later bit is sampled near its middle. The timing comes from a fixed-point clocks-per-bit value, so a clock-to-baud ratio that is not a whole number still lands each sample well inside its bit.

When a frame's single stop bit has been sampled, the lane raises a one-cycle strobe. With it come the assembled word and three error flags: a start bit that read high, a parity mismatch, and a stop bit that read low. A bad start bit does not abort the frame, so the rest of it is still decoded and reported. The settings may only change while both lanes are idle.

Top module: `serial_frame_monitor`

## Requirements
- R1: Each line passes through a two-flop synchronizer. A lane leaves idle only when its synchronized line reads 0 and read 1 one clock earlier. Neither value may come from before reset: a line held low since reset starts nothing until it goes high and then falls again.
- R2: The bit period `cfgPeriod` is in clocks with 8 fractional bits and must be at least 4.0 clocks. The clock in which the fall is seen counts as elapsed time 0. Frame bit n is taken from the synchronized line in the first clock where elapsed×256 ≥ floor(cfgPeriod/2) + n×cfgPeriod. Bit 0 is the start bit and bits 1..N are data.
- R3: `cfgDataBits` sets the data width N, from 5 to 9. Word bits at position N and above are always 0.
- R4: With `cfgMsbFirst`=0, the first data bit on the line lands in word bit 0. With `cfgMsbFirst`=1, it lands in word bit N-1.
- R5: `cfgParity` code 1 selects odd parity and code 2 selects even parity. The parity bit is frame bit N+1. The parity error flag is set when the number of ones in the data plus the parity bit is even for odd mode, or odd for even mode.
- R6: Code 3 expects a parity bit of 0 and code 4 expects a parity bit of 1. Any other parity value sets the parity error flag.
- R7: Code 0 means there is no parity bit. The stop bit is then frame bit N+1, and the parity error flag stays 0. With parity enabled, the stop bit is frame bit N+2.
- R8: A start bit that reads 1 sets the start error flag. The lane still goes on to decode the data, parity and stop bits.
- R9: A stop bit that reads 0 sets the stop error flag. After any stop bit the lane returns to idle and needs a new 1-to-0 transition before it starts another frame.
- R10: The valid output of a lane is high for exactly one clock, the clock after its stop bit is sampled. The word and flags are presented in that same clock.
- R11: The two lanes decode independently, even when their frames overlap in time, and both follow the same settings.
- R12: Holding `rst` high at a clock edge returns both lanes to idle, including a lane in mid-frame, and clears both valid outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgPeriod | input | 24 | Clocks per bit, 8 fractional bits |
| cfgDataBits | input | 4 | Data width, 5 to 9 |
| cfgParity | input | 3 | Parity mode: 0 none, 1 odd, 2 even, 3 zero, 4 one |
| cfgMsbFirst | input | 1 | 1: the first data bit is the word's top bit |
| rxLine | input | 1 | Receive lane serial input |
| txLine | input | 1 | Transmit lane serial input |
| rxValid | output | 1 | Receive lane frame strobe |
| rxData | output | 9 | Receive lane data word |
| rxParityErr | output | 1 | Receive lane parity mismatch |
| rxStartErr | output | 1 | Receive lane start bit read high |
| rxStopErr | output | 1 | Receive lane stop bit read low |
| txValid | output | 1 | Transmit lane frame strobe |
| txData | output | 9 | Transmit lane data word |
| txParityErr | output | 1 | Transmit lane parity mismatch |
| txStartErr | output | 1 | Transmit lane start bit read high |
| txStopErr | output | 1 | Transmit lane stop bit read low |

## Verification
The hardest case to reach from the pins is a frame whose start bit reads high at its midpoint, because a falling edge must still open the frame. The stimulus produces it by pulling the line low for only two clocks and then releasing it for the rest of the start bit. The lane is then sampling data bits it did not expect, and its output is compared against a bench model that computes every sample instant from the fixed-point formula. A non-integer period makes the sample instants drift across the frame, and the overlapping two-lane traffic and the reset in mid-frame are lined up against that same model clock by clock.

// File: rtl/serial_frame_pkg.sv
package serial_frame_pkg;

  localparam int FRAC_BITS = 8;

  typedef enum logic [2:0] {
    PAR_NONE = 3'd0,
    PAR_ODD  = 3'd1,
    PAR_EVEN = 3'd2,
    PAR_ZERO = 3'd3,
    PAR_ONE  = 3'd4
  } parity_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } lane_state_e;

  // Strobes from a lane's control to its datapath, at most one per clock.
  typedef struct packed {
    logic takeStart;
    logic shiftBit;
    logic takeParity;
    logic takeStop;
  } lane_strobe_t;

endpackage

// File: rtl/lane_datapath.sv
module lane_datapath
  import serial_frame_pkg::*;
#(
  parameter int MAX_BITS    = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                lineIn,
  input  logic [3:0]          cfgDataBits,
  input  logic [2:0]          cfgParity,
  input  logic                cfgMsbFirst,
  input  lane_strobe_t        strobe,
  output logic                fallSeen,
  output logic                frameValid,
  output logic [MAX_BITS-1:0] frameData,
  output logic                parityErr,
  output logic                startErr,
  output logic                stopErr
);

  localparam int WARM_MAX = SYNC_STAGES + 1;
  localparam int WARM_W   = $clog2(WARM_MAX + 1);

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   lineSync;
  logic                   prevSync;
  logic [WARM_W-1:0]      warmCnt;
  logic                   primed;
  logic [MAX_BITS-1:0]    wordQ;
  logic                   startBadQ;
  logic                   parBadQ;
  logic                   parityMismatch;
  logic                   onesOdd;

  // Synchronizer chain; its depth is a parameter.
  generate
    if (SYNC_STAGES == 1) begin : g_sync_single
      always_ff @(posedge clk) begin
        if (rst) syncChain <= '1;
        else     syncChain <= lineIn;
      end
    end else begin : g_sync_chain
      always_ff @(posedge clk) begin
        if (rst) syncChain <= '1;
        else     syncChain <= {syncChain[SYNC_STAGES-2:0], lineIn};
      end
    end
  endgenerate

  assign lineSync = syncChain[SYNC_STAGES-1];

  // The warm-up count makes sure the previous sample was taken after reset.
  always_ff @(posedge clk) begin
    if (rst) begin
      warmCnt  <= '0;
      prevSync <= 1'b1;
    end else begin
      prevSync <= lineSync;
      if (warmCnt != WARM_W'(WARM_MAX)) warmCnt <= warmCnt + 1'b1;
    end
  end

  assign primed   = (warmCnt == WARM_W'(WARM_MAX));
  assign fallSeen = primed & prevSync & ~lineSync;

  // Parity check of the word held so far against the current line bit.
  assign onesOdd = (^wordQ) ^ lineSync;

  always_comb begin
    case (parity_mode_e'(cfgParity))
      PAR_ODD:  parityMismatch = ~onesOdd;
      PAR_EVEN: parityMismatch = onesOdd;
      PAR_ZERO: parityMismatch = lineSync;
      PAR_ONE:  parityMismatch = ~lineSync;
      default:  parityMismatch = 1'b0;
    endcase
  end

  // Word assembly and per-frame flags.
  always_ff @(posedge clk) begin
    if (rst) begin
      wordQ     <= '0;
      startBadQ <= 1'b0;
      parBadQ   <= 1'b0;
    end else if (strobe.takeStart) begin
      wordQ     <= '0;
      startBadQ <= lineSync;
      parBadQ   <= 1'b0;
    end else if (strobe.shiftBit) begin
      if (cfgMsbFirst)
        wordQ <= {wordQ[MAX_BITS-2:0], lineSync};
      else
        wordQ <= (wordQ >> 1) | (MAX_BITS'(lineSync) << (cfgDataBits - 4'd1));
    end else if (strobe.takeParity) begin
      parBadQ <= parityMismatch;
    end
  end

  // Registered outputs.
  always_ff @(posedge clk) begin
    if (rst) begin
      frameValid <= 1'b0;
      frameData  <= '0;
      parityErr  <= 1'b0;
      startErr   <= 1'b0;
      stopErr    <= 1'b0;
    end else begin
      frameValid <= strobe.takeStop;
      if (strobe.takeStop) begin
        frameData <= wordQ;
        parityErr <= parBadQ;
        startErr  <= startBadQ;
        stopErr   <= ~lineSync;
      end
    end
  end

  // R10: the frame strobe never lasts two clocks.
  p_valid_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    frameValid |=> !frameValid);

  // R3: the word carries nothing above the set width.
  p_width_clean_r3: assert property (@(posedge clk) disable iff (rst)
    frameValid |-> ((frameData >> cfgDataBits) == '0));

  // R7: no parity sample is taken while parity is off.
  p_no_parity_take_r7: assert property (@(posedge clk) disable iff (rst)
    strobe.takeParity |-> (cfgParity != 3'(PAR_NONE)));

  // R6: a stuck-zero parity flag is set exactly by a set parity bit.
  p_zero_mode_r6: assert property (@(posedge clk) disable iff (rst)
    (strobe.takeParity && cfgParity == 3'(PAR_ZERO)) |=> (parBadQ == $past(lineSync)));

endmodule

// File: rtl/lane_control.sv
module lane_control
  import serial_frame_pkg::*;
#(
  parameter int PERIOD_W = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [PERIOD_W-1:0] cfgPeriod,
  input  logic [3:0]          cfgDataBits,
  input  logic [2:0]          cfgParity,
  input  logic                fallSeen,
  output lane_strobe_t        strobe,
  output logic                busy
);

  localparam int REM_W = PERIOD_W + 2;
  localparam logic signed [REM_W-1:0] ONE_CLOCK = REM_W'(1 << FRAC_BITS);

  lane_state_e              state;
  logic signed [REM_W-1:0]  remTime;
  logic signed [REM_W-1:0]  remNow;
  logic signed [REM_W-1:0]  periodS;
  logic signed [REM_W-1:0]  halfS;
  logic [3:0]               bitIdx;
  logic                     hit;
  logic                     lastData;
  logic                     parityOn;

  assign periodS  = $signed({2'b00, cfgPeriod});
  assign halfS    = $signed({3'b000, cfgPeriod[PERIOD_W-1:1]});
  assign remNow   = remTime - ONE_CLOCK;
  assign busy     = (state != ST_IDLE);
  assign hit      = busy && (remNow <= 0);
  assign lastData = ((bitIdx + 4'd1) == cfgDataBits);
  assign parityOn = (cfgParity != 3'(PAR_NONE));

  always_comb begin
    strobe = '0;
    if (hit) begin
      case (state)
        ST_START:  strobe.takeStart  = 1'b1;
        ST_DATA:   strobe.shiftBit   = 1'b1;
        ST_PARITY: strobe.takeParity = 1'b1;
        ST_STOP:   strobe.takeStop   = 1'b1;
        default:   strobe = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      remTime <= '0;
      bitIdx  <= '0;
    end else begin
      if (state == ST_IDLE) begin
        if (fallSeen) begin
          state   <= ST_START;
          remTime <= halfS;
        end
      end else begin
        remTime <= hit ? (remNow + periodS) : remNow;
        if (hit) begin
          case (state)
            ST_START: begin
              state  <= ST_DATA;
              bitIdx <= '0;
            end
            ST_DATA: begin
              bitIdx <= bitIdx + 4'd1;
              if (lastData) state <= parityOn ? ST_PARITY : ST_STOP;
            end
            ST_PARITY: state <= ST_STOP;
            default:   state <= ST_IDLE;
          endcase
        end
      end
    end
  end

  // R1: a frame opens only after a fall reported by the datapath.
  p_start_on_fall_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(fallSeen));

  // R2: at most one bit is sampled per clock.
  p_one_strobe_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strobe));

  // R9: after the stop sample the lane is idle.
  p_stop_to_idle_r9: assert property (@(posedge clk) disable iff (rst)
    strobe.takeStop |=> !busy);

endmodule

// File: rtl/frame_lane.sv
module frame_lane
  import serial_frame_pkg::*;
#(
  parameter int PERIOD_W    = 24,
  parameter int MAX_BITS    = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                lineIn,
  input  logic [PERIOD_W-1:0] cfgPeriod,
  input  logic [3:0]          cfgDataBits,
  input  logic [2:0]          cfgParity,
  input  logic                cfgMsbFirst,
  output logic                frameValid,
  output logic [MAX_BITS-1:0] frameData,
  output logic                parityErr,
  output logic                startErr,
  output logic                stopErr
);

  lane_strobe_t strobe;
  logic         fallSeen;
  logic         busy;

  lane_control #(.PERIOD_W(PERIOD_W)) i_control (
    .clk         (clk),
    .rst         (rst),
    .cfgPeriod   (cfgPeriod),
    .cfgDataBits (cfgDataBits),
    .cfgParity   (cfgParity),
    .fallSeen    (fallSeen),
    .strobe      (strobe),
    .busy        (busy)
  );

  lane_datapath #(.MAX_BITS(MAX_BITS), .SYNC_STAGES(SYNC_STAGES)) i_datapath (
    .clk         (clk),
    .rst         (rst),
    .lineIn      (lineIn),
    .cfgDataBits (cfgDataBits),
    .cfgParity   (cfgParity),
    .cfgMsbFirst (cfgMsbFirst),
    .strobe      (strobe),
    .fallSeen    (fallSeen),
    .frameValid  (frameValid),
    .frameData   (frameData),
    .parityErr   (parityErr),
    .startErr    (startErr),
    .stopErr     (stopErr)
  );

  // R12: no lane is busy in the clock after a reset.
  p_reset_idle_r12: assert property (@(posedge clk)
    $fell(rst) |-> !busy);

endmodule

// File: rtl/serial_frame_monitor.sv
module serial_frame_monitor #(
  parameter int PERIOD_W    = 24,
  parameter int MAX_BITS    = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [PERIOD_W-1:0] cfgPeriod,
  input  logic [3:0]          cfgDataBits,
  input  logic [2:0]          cfgParity,
  input  logic                cfgMsbFirst,
  input  logic                rxLine,
  input  logic                txLine,
  output logic                rxValid,
  output logic [MAX_BITS-1:0] rxData,
  output logic                rxParityErr,
  output logic                rxStartErr,
  output logic                rxStopErr,
  output logic                txValid,
  output logic [MAX_BITS-1:0] txData,
  output logic                txParityErr,
  output logic                txStartErr,
  output logic                txStopErr
);

  localparam int LANES = 2;

  logic [LANES-1:0]    laneLine;
  logic [LANES-1:0]    laneValid;
  logic [MAX_BITS-1:0] laneData [LANES];
  logic [LANES-1:0]    laneParErr;
  logic [LANES-1:0]    laneStartErr;
  logic [LANES-1:0]    laneStopErr;

  assign laneLine = {txLine, rxLine};

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      frame_lane #(
        .PERIOD_W    (PERIOD_W),
        .MAX_BITS    (MAX_BITS),
        .SYNC_STAGES (SYNC_STAGES)
      ) i_lane (
        .clk         (clk),
        .rst         (rst),
        .lineIn      (laneLine[g]),
        .cfgPeriod   (cfgPeriod),
        .cfgDataBits (cfgDataBits),
        .cfgParity   (cfgParity),
        .cfgMsbFirst (cfgMsbFirst),
        .frameValid  (laneValid[g]),
        .frameData   (laneData[g]),
        .parityErr   (laneParErr[g]),
        .startErr    (laneStartErr[g]),
        .stopErr     (laneStopErr[g])
      );
    end
  endgenerate

  assign rxValid     = laneValid[0];
  assign rxData      = laneData[0];
  assign rxParityErr = laneParErr[0];
  assign rxStartErr  = laneStartErr[0];
  assign rxStopErr   = laneStopErr[0];
  assign txValid     = laneValid[1];
  assign txData      = laneData[1];
  assign txParityErr = laneParErr[1];
  assign txStartErr  = laneStartErr[1];
  assign txStopErr   = laneStopErr[1];

endmodule

// File: tb/test_serial_frame_monitor.sv
module test_serial_frame_monitor;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [23:0] cfgPeriod   = 24'd2688;
  logic [3:0]  cfgDataBits = 4'd8;
  logic [2:0]  cfgParity   = 3'd0;
  logic        cfgMsbFirst = 1'b0;
  logic        rxLine = 1'b1;
  logic        txLine = 1'b1;
  logic        rxValid, txValid;
  logic [8:0]  rxData, txData;
  logic        rxParityErr, rxStartErr, rxStopErr;
  logic        txParityErr, txStartErr, txStopErr;

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  bit    armed = 0;
  bit    done = 0;
  string tag = "R12";

  // Reference model state, per lane.
  int mSt[2];
  int mOrg[2];
  int mN[2];
  int hc[2];
  int h[2][3];
  int mBits[2][9];
  int mStartBad[2];
  int mPar[2];
  int eV[2];
  int eData[2];
  int ePE[2];
  int eSE[2];
  int eTE[2];

  serial_frame_monitor i_serial_frame_monitor (
    .clk (clk), .rst (rst),
    .cfgPeriod (cfgPeriod), .cfgDataBits (cfgDataBits),
    .cfgParity (cfgParity), .cfgMsbFirst (cfgMsbFirst),
    .rxLine (rxLine), .txLine (txLine),
    .rxValid (rxValid), .rxData (rxData), .rxParityErr (rxParityErr),
    .rxStartErr (rxStartErr), .rxStopErr (rxStopErr),
    .txValid (txValid), .txData (txData), .txParityErr (txParityErr),
    .txStartErr (txStartErr), .txStopErr (txStopErr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", tag, what, act, exp, cyc);
    end
  endtask

  // Completes a frame in the model: builds the word and the three flags.
  task automatic modelFinish(int l, int stopVal);
    int n = int'(cfgDataBits);
    int d = 0;
    int ones = 0;
    for (int i = 0; i < n; i++) begin
      ones += mBits[l][i];
      if (cfgMsbFirst) d |= mBits[l][i] << (n - 1 - i);
      else             d |= mBits[l][i] << i;
    end
    case (int'(cfgParity))
      1: ePE[l] = ((ones + mPar[l]) % 2 == 1) ? 0 : 1;
      2: ePE[l] = ((ones + mPar[l]) % 2 == 0) ? 0 : 1;
      3: ePE[l] = (mPar[l] != 0) ? 1 : 0;
      4: ePE[l] = (mPar[l] != 1) ? 1 : 0;
      default: ePE[l] = 0;
    endcase
    eData[l] = d;
    eSE[l] = mStartBad[l];
    eTE[l] = (stopVal != 1) ? 1 : 0;
    eV[l] = 1;
  endtask

  task automatic modelStep(int l, int ln);
    if (rst) begin
      hc[l] = 0; mSt[l] = 0; eV[l] = 0;
    end else begin
      eV[l] = 0;
      if (mSt[l] == 0) begin
        if (hc[l] == 3 && h[l][0] == 1 && h[l][1] == 0) begin
          mSt[l] = 1; mOrg[l] = cyc; mN[l] = 0;
        end
      end else begin
        int el = cyc - mOrg[l];
        int n = int'(cfgDataBits);
        int pe = (cfgParity != 3'd0) ? 1 : 0;
        int target = int'(cfgPeriod) / 2 + mN[l] * int'(cfgPeriod);
        if (el * 256 >= target) begin
          int s = h[l][1];
          if (mN[l] == 0) mStartBad[l] = (s != 0) ? 1 : 0;
          else if (mN[l] <= n) mBits[l][mN[l]-1] = s;
          else if (pe == 1 && mN[l] == n + 1) mPar[l] = s;
          if (mN[l] == n + 1 + pe) begin
            modelFinish(l, s);
            mSt[l] = 0;
          end
          mN[l]++;
        end
      end
      if (hc[l] < 3) begin
        h[l][hc[l]] = ln; hc[l]++;
      end else begin
        h[l][0] = h[l][1]; h[l][1] = h[l][2]; h[l][2] = ln;
      end
    end
  endtask

  always @(posedge clk) begin
    modelStep(0, int'(rxLine));
    modelStep(1, int'(txLine));
    cyc++;
  end

  // R10: every clock, valid and, on a strobe, word and flags.
  always @(negedge clk) begin
    if (armed && !rst && !done) begin
      check("R10 rx valid", int'(rxValid), eV[0]);
      check("R10 tx valid", int'(txValid), eV[1]);
      if (eV[0] == 1) begin
        check("rx data", int'(rxData), eData[0]);
        check("rx parity err", int'(rxParityErr), ePE[0]);
        check("rx start err", int'(rxStartErr), eSE[0]);
        check("rx stop err", int'(rxStopErr), eTE[0]);
      end
      if (eV[1] == 1) begin
        check("tx data", int'(txData), eData[1]);
        check("tx parity err", int'(txParityErr), ePE[1]);
        check("tx start err", int'(txStartErr), eSE[1]);
        check("tx stop err", int'(txStopErr), eTE[1]);
      end
    end
  end

  task automatic setLine(int l, logic v);
    if (l == 0) rxLine = v;
    else        txLine = v;
  endtask

  // Drives one frame with the bench's own bit-period rounding.
  task automatic sendFrame(int l, int value, int flipPar, int badStart, int badStop);
    int n = int'(cfgDataBits);
    int per = int'(cfgPeriod);
    int pm = int'(cfgParity);
    int bits[13];
    int cnt = 0;
    int ones = 0;
    int pbit;
    bits[cnt++] = 0;
    for (int i = 0; i < n; i++) begin
      int b = cfgMsbFirst ? ((value >> (n - 1 - i)) & 1) : ((value >> i) & 1);
      ones += b;
      bits[cnt++] = b;
    end
    if (pm != 0) begin
      case (pm)
        1: pbit = (ones % 2 == 0) ? 1 : 0;
        2: pbit = ones % 2;
        3: pbit = 0;
        default: pbit = 1;
      endcase
      bits[cnt++] = pbit ^ flipPar;
    end
    bits[cnt++] = badStop ? 0 : 1;
    for (int b = 0; b < cnt; b++) begin
      int len = ((b + 1) * per) / 256 - (b * per) / 256;
      for (int c = 0; c < len; c++) begin
        @(negedge clk);
        if (b == 0 && badStart == 1) setLine(l, (c < 2) ? 1'b0 : 1'b1);
        else setLine(l, bits[b][0]);
      end
    end
    @(negedge clk);
    setLine(l, 1'b1);
    repeat ((2 * per) / 256 + 4) @(negedge clk);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: the receive line is held low through reset and after it.
    rxLine = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    armed = 1;
    // R12: reset state at the ports.
    tag = "R12";
    check("rx valid after reset", int'(rxValid), 0);
    check("tx valid after reset", int'(txValid), 0);
    check("rx data after reset", int'(rxData), 0);
    tag = "R1";
    repeat (40) @(negedge clk);
    rxLine = 1'b1;
    repeat (40) @(negedge clk);
    check("no frame from low-at-reset line", int'(rxValid), 0);

    // R2 R4: 8N1, LSB first, fractional period 10.5 clocks.
    tag = "R4";
    sendFrame(0, 'h5A, 0, 0, 0);
    sendFrame(1, 'hC3, 0, 0, 0);
    tag = "R2";
    cfgPeriod = 24'd4096;
    sendFrame(0, 'hA5, 0, 0, 0);
    cfgPeriod = 24'd1100;
    sendFrame(1, 'h3C, 0, 0, 0);

    // R4: MSB first, 7 bits.
    tag = "R4";
    cfgPeriod = 24'd2688;
    cfgMsbFirst = 1'b1;
    cfgDataBits = 4'd7;
    sendFrame(0, 'h41, 0, 0, 0);
    sendFrame(1, 'h0F, 0, 0, 0);

    // R3: widths at both ends.
    tag = "R3";
    cfgDataBits = 4'd5;
    sendFrame(0, 'h1B, 0, 0, 0);
    cfgMsbFirst = 1'b0;
    sendFrame(1, 'h16, 0, 0, 0);
    cfgDataBits = 4'd9;
    sendFrame(0, 'h1A5, 0, 0, 0);
    cfgMsbFirst = 1'b1;
    sendFrame(1, 'h13C, 0, 0, 0);

    // R5: odd and even, good and corrupted parity.
    tag = "R5";
    cfgMsbFirst = 1'b0;
    cfgDataBits = 4'd8;
    cfgParity = 3'd1;
    sendFrame(0, 'h37, 0, 0, 0);
    sendFrame(0, 'h37, 1, 0, 0);
    cfgParity = 3'd2;
    sendFrame(1, 'h81, 0, 0, 0);
    sendFrame(1, 'h81, 1, 0, 0);

    // R6: stuck-zero and stuck-one parity.
    tag = "R6";
    cfgParity = 3'd3;
    sendFrame(0, 'hFF, 0, 0, 0);
    sendFrame(0, 'hFF, 1, 0, 0);
    cfgParity = 3'd4;
    sendFrame(1, 'h00, 0, 0, 0);
    sendFrame(1, 'h00, 1, 0, 0);

    // R7: no parity, stop at bit N+1.
    tag = "R7";
    cfgParity = 3'd0;
    cfgDataBits = 4'd6;
    sendFrame(0, 'h2D, 0, 0, 0);

    // R8: start bit reads high, frame still decoded.
    tag = "R8";
    cfgDataBits = 4'd8;
    cfgParity = 3'd2;
    sendFrame(0, 'h00, 0, 1, 0);
    sendFrame(1, 'hF0, 0, 1, 0);

    // R9: stop bit reads low, then a normal frame.
    tag = "R9";
    cfgParity = 3'd0;
    sendFrame(1, 'h55, 0, 0, 1);
    sendFrame(1, 'h66, 0, 0, 0);

    // R11: overlapping frames on both lanes.
    tag = "R11";
    cfgParity = 3'd1;
    fork
      sendFrame(0, 'h9E, 0, 0, 0);
      sendFrame(1, 'h21, 1, 0, 0);
    join

    // R12: reset in mid-frame, then a clean frame.
    tag = "R12";
    cfgParity = 3'd0;
    fork
      sendFrame(0, 'h77, 0, 0, 0);
      begin
        repeat (40) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
      end
    join
    repeat (60) @(negedge clk);
    check("rx idle after mid-frame reset", int'(rxValid), 0);
    sendFrame(0, 'h12, 0, 0, 0);

    repeat (20) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule